// File: doc/BRIEF.md
# Cascadable Serial Command Receiver for a Dual-Bridge Driver

This block is the serial slave port of a two-bridge motor driver. A host shifts 8-bit command bytes in on a serial data line, MSB first, sampled on rising serial-clock edges while an active-low select is held low. While the bytes shift in, the block returns a status byte on a tristate output. The status byte holds two fault flags supplied by the fault logic, followed by the six command bits that are currently in force. The output changes on falling serial-clock edges. Bits that have passed through the shift register appear on the output eight clocks later, so several devices can share one select line with their data lines chained.

When the select rises, the shifted byte is committed only if the number of serial clocks in the frame was a nonzero multiple of eight. In a chain, each device therefore keeps the last eight bits it received. A committed byte drives two 2-bit current codes and two polarity bits. A one-cycle strobe marks each accepted frame, and the fault logic uses it to clear its latched overload flag. An active-low enable puts the block in standby and resets it. After the enable falls, serial clocks are ignored until a setup interval has passed. The serial pins are brought into a faster system clock through multi-flop synchronizers and edge detectors.

Top module: `spi_cmd_slave`

## Requirements
- R1: While en_n is high, standby is 1 and the command outputs read all ones: cur_a=2'b11, pol_a=1, cur_b=2'b11, pol_b=1 (both bridges off).
- R2: An accepted byte maps as follows: bits 5..4 to cur_a, bit 3 to pol_a, bits 2..1 to cur_b and bit 0 to pol_b. Bits 7..6 of the received byte have no effect.
- R3: At the select rising edge, a frame whose serial clock count is zero or not a multiple of 8 is discarded. The command outputs keep their previous value and no strobe is given.
- R4: In a frame of 16 or more clocks that is a multiple of 8, the last 8 bits shifted in are the byte that is committed.
- R5: The first 8 bits returned on sdo in a frame are {err_in[1:0], cur_a, pol_a, cur_b, pol_b}, MSB first. They are captured when the select falls.
- R6: From the ninth clock of a frame onward, sdo returns the sdi bits of the same frame delayed by exactly 8 clocks.
- R7: sdo is high impedance whenever cs_n is high.
- R8: frame_ok pulses high for exactly one system clock per accepted frame, and never for a discarded one.
- R9: Serial clocks arriving within SETUP_CYCLES system clocks after standby ends are not counted. A frame made only of such clocks is discarded.
- R10: While en_n is high, frames have no effect on the command outputs and give no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| en_n | input | 1 | Active-low enable; high means standby and reset |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in |
| err_in | input | 2 | Fault flags placed in status bits 7..6 |
| sdo | output | 1 | Serial data out, tristate |
| cur_a | output | 2 | Committed current code of bridge A |
| pol_a | output | 1 | Committed polarity of bridge A |
| cur_b | output | 2 | Committed current code of bridge B |
| pol_b | output | 1 | Committed polarity of bridge B |
| frame_ok | output | 1 | One-cycle strobe on each accepted frame (clears the overload flag) |
| standby | output | 1 | High while the block is held in standby |

## Verification
The bench builds the block with SYNC_STAGES=2 and SETUP_CYCLES=400. With these values a whole 8-bit frame fits inside the setup window right after the enable falls, so the rule that early clocks are ignored is tested directly. The later frames then start well clear of that window. The serial clock runs at one twentieth of the system clock, which leaves the synchronizer latency well inside each serial half period. Random frames of 1 to 31 bits and chains of up to three bytes exercise the length rule and the 8-bit pass-through.

// File: rtl/spicmd_pkg.sv
`timescale 1ns/1ps
package spicmd_pkg;
  localparam int BYTE_W  = 8;
  localparam int CMD_W   = 6;
  localparam int CNT_W   = $clog2(BYTE_W);
  localparam logic [CMD_W-1:0] CMD_OFF = '1;

  // A frame counts only if some clock arrived and the count is a whole number of bytes.
  function automatic logic frame_len_ok(input logic [CNT_W-1:0] lo, input logic any);
    return any && (lo == '0);
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic [1:0] err,
                                                    input logic [CMD_W-1:0] cmd);
    return {err, cmd};
  endfunction
endpackage

// File: rtl/spicmd_sync.sv
`timescale 1ns/1ps
module spicmd_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or posedge rst)
        if (rst) st[g] <= RST_VAL;
        else     st[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or posedge rst)
        if (rst) st[g] <= RST_VAL;
        else     st[g] <= st[g-1];
    end
  end
  assign q = st[STAGES-1];
endmodule

// File: rtl/spicmd_shifter.sv
`timescale 1ns/1ps
module spicmd_shifter
  import spicmd_pkg::*;
(
  input  logic              clk,
  input  logic              stby,
  input  logic              ready,
  input  logic              cs_s,
  input  logic              cs_fall,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi_s,
  input  logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] shreg,
  output logic              sdo_q,
  output logic [CNT_W-1:0]  cnt_lo,
  output logic              cnt_any
);
  logic bit_in, bit_out;
  assign bit_in  = !cs_s && ready && sck_rise;
  assign bit_out = !cs_s && ready && sck_fall;

  always_ff @(posedge clk or posedge stby) begin
    if (stby) begin
      shreg   <= '1;
      sdo_q   <= 1'b1;
      cnt_lo  <= '0;
      cnt_any <= 1'b0;
    end else if (cs_fall) begin
      shreg   <= status;
      sdo_q   <= status[BYTE_W-1];
      cnt_lo  <= '0;
      cnt_any <= 1'b0;
    end else if (bit_in) begin
      shreg   <= {shreg[BYTE_W-2:0], sdi_s};
      cnt_lo  <= cnt_lo + 1'b1;
      cnt_any <= 1'b1;
    end else if (bit_out) begin
      sdo_q   <= shreg[BYTE_W-1];
    end
  end
endmodule

// File: rtl/spicmd_commit.sv
`timescale 1ns/1ps
module spicmd_commit
  import spicmd_pkg::*;
(
  input  logic              clk,
  input  logic              stby,
  input  logic              cs_rise,
  input  logic [CNT_W-1:0]  cnt_lo,
  input  logic              cnt_any,
  input  logic [BYTE_W-1:0] shreg,
  output logic [CMD_W-1:0]  cmd_q,
  output logic              frame_ok
);
  logic accept;
  assign accept = cs_rise && frame_len_ok(cnt_lo, cnt_any);

  always_ff @(posedge clk or posedge stby) begin
    if (stby) begin
      cmd_q    <= CMD_OFF;
      frame_ok <= 1'b0;
    end else begin
      frame_ok <= accept;
      if (accept) cmd_q <= shreg[CMD_W-1:0];
    end
  end
endmodule

// File: rtl/spi_cmd_slave.sv
`timescale 1ns/1ps
module spi_cmd_slave
  import spicmd_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int SETUP_CYCLES = 3000
) (
  input  logic       clk,
  input  logic       en_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  input  logic [1:0] err_in,
  output logic       sdo,
  output logic [1:0] cur_a,
  output logic       pol_a,
  output logic [1:0] cur_b,
  output logic       pol_b,
  output logic       frame_ok,
  output logic       standby
);
  localparam int SW = $clog2(SETUP_CYCLES + 1);

  // Standby: set at once by en_n, released two system clocks after it falls.
  logic [1:0] sb_q;
  always_ff @(posedge clk or posedge en_n)
    if (en_n) sb_q <= 2'b11;
    else      sb_q <= {sb_q[0], 1'b0};
  logic stby;
  assign stby    = sb_q[1];
  assign standby = stby;

  // Setup window after standby ends.
  logic [SW-1:0] setup_cnt;
  logic          ready;
  always_ff @(posedge clk or posedge stby)
    if (stby) begin
      setup_cnt <= '0;
      ready     <= 1'b0;
    end else if (!ready) begin
      if (setup_cnt == SW'(SETUP_CYCLES)) ready <= 1'b1;
      else setup_cnt <= setup_cnt + 1'b1;
    end

  // Synchronize the serial pins: {cs, sck, sdi}.
  logic [2:0] pins_s;
  spicmd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(stby), .d({cs_n, sck, sdi}), .q(pins_s)
  );
  logic cs_s, sck_s, sdi_s, cs_d, sck_d;
  assign {cs_s, sck_s, sdi_s} = pins_s;
  always_ff @(posedge clk or posedge stby)
    if (stby) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end

  logic cs_fall, cs_rise, sck_rise, sck_fall;
  assign cs_fall  = cs_d && !cs_s;
  assign cs_rise  = !cs_d && cs_s;
  assign sck_rise = !sck_d && sck_s;
  assign sck_fall = sck_d && !sck_s;

  logic [CMD_W-1:0]  cmd_q;
  logic [BYTE_W-1:0] shreg;
  logic              sdo_q, cnt_any;
  logic [CNT_W-1:0]  cnt_lo;

  spicmd_shifter u_shift (
    .clk(clk), .stby(stby), .ready(ready), .cs_s(cs_s), .cs_fall(cs_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s),
    .status(status_byte(err_in, cmd_q)), .shreg(shreg), .sdo_q(sdo_q),
    .cnt_lo(cnt_lo), .cnt_any(cnt_any)
  );

  spicmd_commit u_commit (
    .clk(clk), .stby(stby), .cs_rise(cs_rise), .cnt_lo(cnt_lo),
    .cnt_any(cnt_any), .shreg(shreg), .cmd_q(cmd_q), .frame_ok(frame_ok)
  );

  assign {cur_a, pol_a, cur_b, pol_b} = cmd_q;
  assign sdo = cs_n ? 1'bz : sdo_q;
endmodule

// File: rtl/spicmd_chk.sv
`timescale 1ns/1ps
module spicmd_chk (
  input logic       clk,
  input logic       stby,
  input logic       ready,
  input logic       frame_ok,
  input logic [5:0] cmd_q,
  input logic [2:0] cnt_lo,
  input logic       cnt_any
);
  assert_off_in_standby_R1: assert property (@(posedge clk)
    stby |-> (cmd_q == 6'h3F));

  assert_hold_unless_accepted_R3: assert property (@(posedge clk) disable iff (stby)
    !$stable(cmd_q) |-> frame_ok);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (stby)
    frame_ok |=> !frame_ok);

  assert_no_count_in_setup_R9: assert property (@(posedge clk) disable iff (stby)
    !ready |-> (!cnt_any && cnt_lo == 3'd0));
endmodule

bind spi_cmd_slave spicmd_chk u_chk (
  .clk(clk), .stby(stby), .ready(ready), .frame_ok(frame_ok),
  .cmd_q(cmd_q), .cnt_lo(cnt_lo), .cnt_any(cnt_any)
);

// File: tb/sim_spi_cmd_slave.sv
`timescale 1ns/1ps
module sim_spi_cmd_slave;
  localparam int HALF = 100;  // serial half period in ns

  logic clk = 1'b0;
  logic en_n = 1'b1, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [1:0] err_in = 2'b00;
  logic sdo, pol_a, pol_b, frame_ok, standby;
  logic [1:0] cur_a, cur_b;

  always #5 clk = ~clk;

  spi_cmd_slave #(.SYNC_STAGES(2), .SETUP_CYCLES(400)) u0 (
    .clk(clk), .en_n(en_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .err_in(err_in),
    .sdo(sdo), .cur_a(cur_a), .pol_a(pol_a), .cur_b(cur_b), .pol_b(pol_b),
    .frame_ok(frame_ok), .standby(standby)
  );

  int n_chk = 0, n_bad = 0, pulses = 0, hi_cycles = 0;
  bit done = 0;
  logic fo_prev = 1'b0;
  logic [5:0] exp_cmd = 6'h3F;
  int exp_pulses = 0;

  always @(posedge clk) begin
    if (frame_ok === 1'b1) hi_cycles++;
    if (frame_ok === 1'b1 && fo_prev !== 1'b1) pulses++;
    fo_prev <= frame_ok;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] cmd_now();
    return {cur_a, pol_a, cur_b, pol_b};
  endfunction

  function automatic logic len_ok(input int n);
    return (n > 0) && (n % 8 == 0);
  endfunction

  // Expected returned bits: status byte first, then the sent bits 8 clocks late.
  function automatic logic [31:0] exp_sdo(input int n, input logic [31:0] data,
                                           input logic [7:0] st);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++)
      r[n-1-i] = (i < 8) ? st[7-i] : data[n-1-(i-8)];
    return r;
  endfunction

  task automatic frame(input int n, input logic [31:0] data, output logic [31:0] got);
    got = '0;
    cs_n = 1'b0;
    #(HALF);
    for (int i = 0; i < n; i++) begin
      sdi = data[n-1-i];
      #(HALF);
      got[n-1-i] = sdo;
      sck = 1'b1;
      #(HALF);
      sck = 1'b0;
    end
    #(HALF);
    cs_n = 1'b1;
    #(3*HALF);
  endtask

  // Full frame plus all checks while the block is operating.
  task automatic run(input int n, input logic [31:0] data, input string tag);
    logic [31:0] got;
    logic [7:0] st;
    st = {err_in, exp_cmd};
    frame(n, data, got);
    if (n > 0) chk({tag, " sdo stream R5 R6"}, got, exp_sdo(n, data, st));
    if (len_ok(n)) begin
      exp_cmd = data[5:0];
      exp_pulses++;
    end
    chk({tag, " command R2 R3 R4"}, 32'(cmd_now()), 32'(exp_cmd));
    chk({tag, " strobe count R8"}, pulses, exp_pulses);
  endtask

  initial begin
    logic [31:0] got;
    void'($urandom(32'h5EED_1234));
    #3;
    #(200);
    // Reset / standby state
    chk("R1 standby flag", 32'(standby), 1);
    chk("R1 command all ones", 32'(cmd_now()), 32'h3F);
    chk("R7 sdo idle high-z", 32'(sdo === 1'bz), 1);

    // Frame during standby is ignored
    frame(8, 32'h00, got);
    chk("R10 standby frame command", 32'(cmd_now()), 32'h3F);
    chk("R10 standby frame strobe", pulses, 0);

    // Release enable and clock a frame inside the setup window
    en_n = 1'b0;
    #(50);
    frame(8, 32'h00, got);
    chk("R9 early frame command", 32'(cmd_now()), 32'h3F);
    chk("R9 early frame strobe", pulses, 0);
    chk("R1 standby released", 32'(standby), 0);
    #(5000);

    err_in = 2'b10;
    run(8, 32'h00, "R2 all-on byte");
    err_in = 2'b01;
    run(8, 32'hC5, "R2 top bits ignored");
    run(0, 32'h0, "R3 zero-length");
    run(7, 32'h2A, "R3 seven bits");
    run(9, 32'h1FF, "R3 nine bits");
    err_in = 2'b11;
    run(16, 32'hAB12, "R4 two-byte chain");
    run(24, 32'h3C_5A_29, "R4 three-byte chain");
    chk("R7 sdo high-z after frame", 32'(sdo === 1'bz), 1);

    for (int k = 0; k < 30; k++) begin
      int n;
      logic [31:0] d;
      err_in = 2'($urandom);
      n = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 31) : 8 * $urandom_range(1, 3);
      d = $urandom;
      if (n < 32) d = d & ((32'h1 << n) - 1);
      run(n, d, "random");
    end

    chk("R8 strobe one cycle each", hi_cycles, exp_pulses);
    chk("R7 sdo high-z at end", 32'(sdo === 1'bz), 1);

    en_n = 1'b1;
    #(100);
    chk("R1 re-entered standby", 32'(standby), 1);
    chk("R1 command reset", 32'(cmd_now()), 32'h3F);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(1500000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule